// File: doc/BRIEF.md
# Burst-Threshold FIFO Host Bridge

This block sits between a producing datapath and a host processor. Data words from the producer enter a circular buffer through a write port. Once the number of stored words reaches a host-chosen burst level, the block raises an interrupt toward the host. The host then pulls words out one at a time through a register-style read port. It is signalled once per burst, not once per word. The producer keeps filling the buffer during this time, so the interrupt comes back each time the occupancy reaches the level again.

The block is built so that a lost interrupt cannot stall the link for good. The interrupt is a held level, not a pulse. A watchdog marks a pending burst that nobody drains. A single clear command empties the buffer and puts every flag back to its initial state. Writes that arrive while the buffer is full are dropped and recorded in a sticky overflow flag. Reads from an empty buffer are recorded in a sticky underflow flag and change nothing else.

The nominal system drains bursts of 4092 words, which calls for `ADDR_W = 12`. The default build is smaller. The burst level must lie between 1 and the depth.

Top module: `burst_fifo_bridge`

## Requirements
- R1: After reset, occupancy is 0, `rdData` is 0, and `irq`, `overflow`, `underflow` and `stall` are all low.
- R2: A write to a buffer that is not full stores the word and raises occupancy by one. A read from a buffer that is not empty lowers occupancy by one and presents the oldest stored word on `rdData` in the cycle after `rdEn`. Words come out in the order they were written.
- R3: A write while occupancy equals the depth (2^ADDR_W) is dropped, even if a read happens in the same cycle. Occupancy does not rise, the stored words are unchanged, and `overflow` goes high and stays high.
- R4: `overflowClr` lowers `overflow`. `underflowClr` lowers `underflow`. If a new event occurs in the same cycle as the clear, the flag stays set.
- R5: A read while occupancy is 0 leaves `rdData` and occupancy unchanged and sets a sticky `underflow` flag.
- R6: `irq` is high exactly when occupancy is at or above `burstLevel` and the current burst has not been acknowledged.
- R7: `irqAck` lowers `irq`. `irq` stays low while occupancy remains at or above `burstLevel`. Once occupancy falls below the level, the acknowledgement is forgotten, and `irq` rises again the next time occupancy reaches the level.
- R8: While `irq` is high and no read is made, a watchdog counts cycles. A read, or `irq` going low, resets the count. If `irq` stays high for `stallLimit`+1 consecutive cycles with no read, `stall` goes high after the last of them and stays high.
- R9: `clearCmd` empties the buffer. It sets occupancy and `rdData` to 0, lowers `overflow`, `underflow`, `stall` and `irq`, and forgets any acknowledgement. It overrides a write or read in the same cycle.
- R10: A write and a read in the same cycle, with the buffer neither empty nor full, leave occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Producer write strobe |
| wrData | input | DATA_W | Producer data word |
| rdEn | input | 1 | Host read strobe |
| rdData | output | DATA_W | Word returned by the last successful read |
| irqAck | input | 1 | Host acknowledges the pending burst |
| clearCmd | input | 1 | Host flush and restart |
| overflowClr | input | 1 | Clears the overflow flag |
| underflowClr | input | 1 | Clears the underflow flag |
| burstLevel | input | ADDR_W+1 | Occupancy that raises the interrupt |
| stallLimit | input | TO_W | Watchdog timeout in cycles |
| occupancy | output | ADDR_W+1 | Number of words stored |
| irq | output | 1 | Burst-ready interrupt, held as a level |
| overflow | output | 1 | Sticky flag: a write was dropped |
| underflow | output | 1 | Sticky flag: an empty read occurred |
| stall | output | 1 | Sticky flag: a pending burst was left undrained |

## Verification
The hardest states to reach are the full buffer and the watchdog timeout. Each needs a long run of writes with no reads while the interrupt is pending, and balanced random traffic never produces that. The stimulus therefore alternates random phases with different read and write rates, some of them write-only with no acknowledgement. These phases drive the buffer past its depth and hold `irq` for more than `stallLimit` cycles. Directed steps then recover with the clear command and check that bursts repeat after an acknowledgement.

// File: rtl/bfb_pkg.sv
package bfb_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoStrobe_t;
endpackage

// File: rtl/bfb_datapath.sv
module bfb_datapath
  import bfb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr;

  // storage has no reset; only pointers and output are initialised
  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else if (strobe.flush) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (strobe.pop) begin
        rdPtr  <= rdPtr + 1'b1;
        rdData <= mem[rdPtr];
      end
    end
  end
endmodule

// File: rtl/bfb_control.sv
module bfb_control
  import bfb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              irqAck,
  input  logic              clearCmd,
  input  logic              overflowClr,
  input  logic              underflowClr,
  input  logic [ADDR_W:0]   burstLevel,
  input  logic [TO_W-1:0]   stallLimit,
  output fifoStrobe_t       strobe,
  output logic [ADDR_W:0]   occupancy,
  output logic              irq,
  output logic              overflow,
  output logic              underflow,
  output logic              stall
);
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(1 << ADDR_W);

  logic             full, empty, acked;
  logic [CNT_W-1:0] countNext;
  logic [TO_W-1:0]  wdCnt;
  logic             dropWrite, emptyRead, wdRun;

  assign full  = (occupancy == FULL_CNT);
  assign empty = (occupancy == '0);

  assign strobe.flush = clearCmd;
  assign strobe.push  = wrEn && !full && !clearCmd;
  assign strobe.pop   = rdEn && !empty && !clearCmd;

  assign dropWrite = wrEn && full && !clearCmd;
  assign emptyRead = rdEn && empty && !clearCmd;
  assign wdRun     = irq && !rdEn;

  always_comb begin
    countNext = occupancy;
    if (strobe.flush) countNext = '0;
    else begin
      unique case ({strobe.push, strobe.pop})
        2'b10:   countNext = occupancy + 1'b1;
        2'b01:   countNext = occupancy - 1'b1;
        default: countNext = occupancy;
      endcase
    end
  end

  assign irq = (occupancy >= burstLevel) && !acked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occupancy <= '0;
      acked     <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      stall     <= 1'b0;
      wdCnt     <= '0;
    end else begin
      occupancy <= countNext;
      if (strobe.flush || countNext < burstLevel) acked <= 1'b0;
      else if (irqAck)                            acked <= 1'b1;

      if (strobe.flush)     overflow <= 1'b0;
      else if (dropWrite)   overflow <= 1'b1;
      else if (overflowClr) overflow <= 1'b0;

      if (strobe.flush)      underflow <= 1'b0;
      else if (emptyRead)    underflow <= 1'b1;
      else if (underflowClr) underflow <= 1'b0;

      if (strobe.flush)                      stall <= 1'b0;
      else if (wdRun && wdCnt >= stallLimit) stall <= 1'b1;

      if (strobe.flush || !wdRun) wdCnt <= '0;
      else if (wdCnt != '1)       wdCnt <= wdCnt + 1'b1;
    end
  end
endmodule

// File: rtl/burst_fifo_bridge.sv
module burst_fifo_bridge
  import bfb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              irqAck,
  input  logic              clearCmd,
  input  logic              overflowClr,
  input  logic              underflowClr,
  input  logic [ADDR_W:0]   burstLevel,
  input  logic [TO_W-1:0]   stallLimit,
  output logic [ADDR_W:0]   occupancy,
  output logic              irq,
  output logic              overflow,
  output logic              underflow,
  output logic              stall
);
  fifoStrobe_t strobe;

  bfb_control #(.ADDR_W(ADDR_W), .TO_W(TO_W)) u_control (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .irqAck(irqAck),
    .clearCmd(clearCmd), .overflowClr(overflowClr), .underflowClr(underflowClr),
    .burstLevel(burstLevel), .stallLimit(stallLimit), .strobe(strobe),
    .occupancy(occupancy), .irq(irq), .overflow(overflow),
    .underflow(underflow), .stall(stall)
  );

  bfb_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/bfb_checker.sv
module bfb_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int TO_W   = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic              irqAck,
  input logic              clearCmd,
  input logic [ADDR_W:0]   burstLevel,
  input logic [DATA_W-1:0] rdData,
  input logic [ADDR_W:0]   occupancy,
  input logic              irq,
  input logic              overflow,
  input logic              underflow,
  input logic              stall
);
  localparam logic [ADDR_W:0] FULL_CNT = (ADDR_W+1)'(1 << ADDR_W);

  p_occ_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= FULL_CNT);

  p_pop_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && !clearCmd && occupancy != '0) |=> occupancy == $past(occupancy) - 1'b1);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdEn && !clearCmd && occupancy == FULL_CNT) |=> ($stable(occupancy) && overflow));

  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !clearCmd && occupancy == '0) |=> ($stable(rdData) && underflow));

  p_irq_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> occupancy >= burstLevel);

  p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irq && irqAck && !clearCmd) |=> !irq);

  p_stall_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stall) |-> $past(irq) && !$past(rdEn));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    clearCmd |=> (occupancy == '0 && !overflow && !underflow && !stall));

  p_both_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdEn && !clearCmd && occupancy != '0 && occupancy != FULL_CNT) |=> $stable(occupancy));
endmodule

bind burst_fifo_bridge bfb_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TO_W(TO_W)) u_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .irqAck(irqAck),
  .clearCmd(clearCmd), .burstLevel(burstLevel), .rdData(rdData),
  .occupancy(occupancy), .irq(irq), .overflow(overflow),
  .underflow(underflow), .stall(stall)
);

// File: tb/burst_fifo_bridge_bench.sv
module burst_fifo_bridge_bench;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;
  localparam int TO_W   = 16;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LEVEL  = 12;
  localparam int LIMIT  = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0, rdEn = 0, irqAck = 0, clearCmd = 0, overflowClr = 0, underflowClr = 0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic [ADDR_W:0]   burstLevel = (ADDR_W+1)'(LEVEL);
  logic [TO_W-1:0]   stallLimit = TO_W'(LIMIT);
  logic [ADDR_W:0]   occupancy;
  logic irq, overflow, underflow, stall;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // reference model state
  int q[$];
  int expRd = 0, wd = 0;
  bit acked = 0, expOvf = 0, expUnf = 0, expStall = 0;

  always #2 clk = ~clk;

  burst_fifo_bridge #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TO_W(TO_W)) u_burst_fifo_bridge (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .irqAck(irqAck), .clearCmd(clearCmd), .overflowClr(overflowClr),
    .underflowClr(underflowClr), .burstLevel(burstLevel), .stallLimit(stallLimit),
    .occupancy(occupancy), .irq(irq), .overflow(overflow), .underflow(underflow),
    .stall(stall)
  );

  function automatic bit expIrq();
    return (q.size() >= LEVEL) && !acked;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll();
    chk("R2", "occupancy", int'(occupancy), q.size());
    chk("R2", "rdData", int'(rdData), expRd);
    chk("R6", "irq", int'(irq), int'(expIrq()));
    chk("R3", "overflow", int'(overflow), int'(expOvf));
    chk("R5", "underflow", int'(underflow), int'(expUnf));
    chk("R8", "stall", int'(stall), int'(expStall));
  endtask

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(bit w, int d, bit r, bit a, bit c, bit oc, bit uc);
    bit preIrq, full, empty;
    wrEn = w; wrData = DATA_W'(d); rdEn = r; irqAck = a;
    clearCmd = c; overflowClr = oc; underflowClr = uc;
    preIrq = expIrq();
    full = (q.size() == DEPTH);
    empty = (q.size() == 0);
    @(posedge clk);
    if (c) begin
      q.delete(); expRd = 0; acked = 0; expOvf = 0; expUnf = 0; expStall = 0; wd = 0;
    end else begin
      if (preIrq && !r && wd >= LIMIT) expStall = 1;
      wd = (preIrq && !r) ? wd + 1 : 0;
      if (r && !empty) expRd = q.pop_front();
      if (w && !full) q.push_back(d & 16'hFFFF);
      if (w && full) expOvf = 1; else if (oc) expOvf = 0;
      if (r && empty) expUnf = 1; else if (uc) expUnf = 0;
      if (q.size() < LEVEL) acked = 0; else if (a) acked = 1;
    end
    @(negedge clk);
    checkAll();
  endtask

  task automatic randPhase(int n, int wrPct, int rdPct, int ackPct);
    for (int i = 0; i < n; i++)
      step($urandom_range(99) < wrPct, $urandom_range(65535), $urandom_range(99) < rdPct,
           $urandom_range(99) < ackPct, $urandom_range(999) < 2,
           $urandom_range(99) < 5, $urandom_range(99) < 5);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "occupancy after reset", int'(occupancy), 0);
    chk("R1", "flags after reset", int'({irq, overflow, underflow, stall}), 0);
    chk("R1", "rdData after reset", int'(rdData), 0);

    // R5 empty read, then R4 underflow clear
    step(0, 0, 1, 0, 0, 0, 0);
    chk("R5", "underflow on empty read", int'(underflow), 1);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R4", "underflow cleared", int'(underflow), 0);

    // R6 fill to level, R7 ack then re-arm
    for (int i = 0; i < LEVEL; i++) step(1, 100 + i, 0, 0, 0, 0, 0);
    chk("R6", "irq at level", int'(irq), 1);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R7", "irq after ack", int'(irq), 0);
    step(1, 200, 0, 0, 0, 0, 0);
    chk("R7", "irq stays low above level", int'(irq), 0);
    step(0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    chk("R7", "below level", int'(occupancy), LEVEL - 1);
    step(1, 201, 0, 0, 0, 0, 0);
    chk("R7", "irq re-armed", int'(irq), 1);

    // R10 simultaneous read and write
    step(1, 202, 1, 0, 0, 0, 0);
    chk("R10", "occupancy unchanged", int'(occupancy), LEVEL);

    // R8 watchdog: stall rises after LIMIT+1 idle pending cycles
    for (int i = 0; i < LIMIT; i++) step(0, 0, 0, 0, 0, 0, 0);
    chk("R8", "no stall yet", int'(stall), 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R8", "stall set", int'(stall), 1);

    // R3 overflow by filling past depth, then R4 clear
    for (int i = 0; i < DEPTH; i++) step(1, 300 + i, 0, 0, 0, 0, 0);
    chk("R3", "full occupancy", int'(occupancy), DEPTH);
    chk("R3", "overflow set", int'(overflow), 1);
    step(1, 999, 1, 0, 0, 0, 0);
    chk("R3", "write dropped with read", int'(occupancy), DEPTH - 1);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R4", "overflow cleared", int'(overflow), 0);

    // R9 clear overrides a same-cycle write
    step(1, 5, 1, 0, 1, 0, 0);
    chk("R9", "occupancy after clear", int'(occupancy), 0);
    chk("R9", "flags after clear", int'({irq, overflow, underflow, stall}), 0);
    chk("R9", "rdData after clear", int'(rdData), 0);

    // constrained random phases
    for (int p = 0; p < 30; p++) begin
      randPhase(150, 70, 50, 10);
      randPhase(60, 90, 0, 0);
      randPhase(150, 40, 80, 10);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule